// File: doc/BRIEF.md
# Multi-Bank Programmable Clock Divider

This block divides one fast clock into twelve outputs in three banks of four, plus a feedback output. Each bank has a 2-bit ratio select. The feedback path has a 3-bit select whose top bit doubles the base ratio. Every ratio is even, and each divided clock has a 50% duty cycle.

Each output can be held low through a parallel freeze mask while its bank counter keeps running. An output is frozen or released only while it is already low. A released output therefore comes back in phase with its siblings and never shows a shortened pulse.

An inversion control flips the two upper outputs of the third bank. A low output-enable resets all counters together and drops a separate enable flag. A synchronous power-on reset also clears every freeze.

Top module: `clkdiv_banks`

## Requirements
- R1: Bank A (`clk_a`) divides by 4, 6, 8 or 12 for `sel_a` = 0, 1, 2 or 3. The output is high for the first half of each period and low for the second half.
- R2: Bank B (`clk_b`) divides by 4, 6, 8 or 10 for `sel_b` = 0, 1, 2 or 3, with a 50% duty cycle.
- R3: Bank C (`clk_c`) divides by 2, 4, 6 or 8 for `sel_c` = 0, 1, 2 or 3, with a 50% duty cycle.
- R4: `clk_fb` divides by 4, 6, 8 or 10 for `sel_fb[1:0]` = 0..3. When `sel_fb[2]` is 1, that ratio is doubled (8, 12, 16, 20).
- R5: When bit i of `freeze` is 1, output i is held low. Bits 0-3 map to `clk_a`, bits 4-7 to `clk_b` and bits 8-11 to `clk_c`. The bank counter keeps running, so a released output is identical to an output that was never frozen.
- R6: A freeze bit is taken into account only on a clock edge where the affected output was low just before the edge. No output pulse is ever shorter than the half period of its divider.
- R7: While `inv_c` is 1, `clk_c[2]` and `clk_c[3]` are the complement of the bank C divided clock, before freeze gating. While it is 0, they are not inverted.
- R8: While `out_en` is 0, all counters are held reset with every divided clock low. `drive_en` is the value of `out_en` (forced 0 by `rst`) registered on the clock.
- R9: `rst` (synchronous, active high) resets the counters and clears every freeze, so that all outputs are enabled.
- R10: On the first clock edge after reset ends, all divided clocks rise together. Their rising edges then coincide wherever their periods share a multiple.
- R11: A select change is applied only at the start of the next period of that divider. The period in progress keeps its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| out_en | input | 1 | Low resets the dividers and disables the outputs |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| sel_fb | input | 3 | Feedback ratio select; top bit doubles |
| inv_c | input | 1 | Inverts the two upper bank C outputs |
| freeze | input | 12 | Per-output freeze mask (1 = hold low) |
| clk_a | output | 4 | Bank A outputs |
| clk_b | output | 4 | Bank B outputs |
| clk_c | output | 4 | Bank C outputs |
| clk_fb | output | 1 | Feedback output |
| drive_en | output | 1 | Output-enable flag |

## Verification
The assertions assume that every control input is synchronous to `clk` and settles between edges. The freeze-edge checks also rely on `inv_c` flipping the raw phase before gating. If `inv_c` changed in the middle of a high half, the released output would follow that flip, and the reference model does the same. The stimulus changes every input only on the falling clock edge.

The stimulus moves the freeze mask and the selects at odd intervals so that changes land in both halves of each period. It toggles `inv_c` while outputs are frozen and released, so the freeze-edge checks see inverted outputs as well.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int HALF_W        = 4;
    localparam int NUM_BANKS     = 3;
    localparam int OUTS_PER_BANK = 4;
    localparam int NUM_OUTS      = NUM_BANKS * OUTS_PER_BANK;

    typedef logic [HALF_W-1:0] half_t;

    typedef enum logic [1:0] {
        BANK_A  = 2'd0,
        BANK_B  = 2'd1,
        BANK_C  = 2'd2,
        BANK_FB = 2'd3
    } bank_e;

    typedef struct packed {
        logic  phase;
        half_t count;
        half_t span;
    } div_state_t;

    // Half period in fast-clock cycles for a 2-bit select
    function automatic half_t half_of(bank_e kind, logic [1:0] s);
        half_t h;
        case (kind)
            BANK_A: begin
                case (s)
                    2'd0:    h = half_t'(2);
                    2'd1:    h = half_t'(3);
                    2'd2:    h = half_t'(4);
                    default: h = half_t'(6);
                endcase
            end
            BANK_C:  h = half_t'(s) + half_t'(1);
            default: h = half_t'(s) + half_t'(2);
        endcase
        return h;
    endfunction

endpackage

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
    import clkdiv_pkg::*;
#(
    parameter bank_e KIND  = BANK_A,
    parameter int    SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             phase
);

    half_t      next_half;
    div_state_t st;

    generate
        if (KIND == BANK_FB) begin : g_doubled
            half_t base;
            assign base      = half_of(BANK_B, sel[1:0]);
            assign next_half = sel[SEL_W-1] ? half_t'(base << 1) : base;
        end else begin : g_direct
            assign next_half = half_of(KIND, sel[1:0]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (st.count == '0) begin
            st.phase <= ~st.phase;
            if (!st.phase) begin
                st.span  <= next_half;
                st.count <= next_half - half_t'(1);
            end else begin
                st.count <= st.span - half_t'(1);
            end
        end else begin
            st.count <= st.count - half_t'(1);
        end
    end

    assign phase = st.phase;

    // R1: the phase may only move on a terminal count
    assert_phase_steady_R1: assert property (@(posedge clk) disable iff (rst)
        (st.count != '0) |=> $stable(phase));

    // R11: a period's length never changes while it is counting
    assert_span_steady_R11: assert property (@(posedge clk) disable iff (rst)
        (st.count != '0) |=> $stable(st.span));

endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic freeze,
    output logic q
);

    logic hold;

    always_ff @(posedge clk) begin
        if (rst)       hold <= 1'b0;
        else if (!raw) hold <= freeze;
    end

    assign q = raw & ~hold;

    // R6: output edges only ever coincide with edges of the raw divided clock
    assert_clean_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(q) |-> $rose(raw));
    assert_clean_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(q) |-> $fell(raw));

    // R5: a freeze requested while low keeps the output low next cycle
    assert_frozen_low_R5: assert property (@(posedge clk) disable iff (rst)
        (freeze && !raw) |=> !q);

endmodule

// File: rtl/clkdiv_banks.sv
module clkdiv_banks
    import clkdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        out_en,
    input  logic [1:0]  sel_a,
    input  logic [1:0]  sel_b,
    input  logic [1:0]  sel_c,
    input  logic [2:0]  sel_fb,
    input  logic        inv_c,
    input  logic [11:0] freeze,
    output logic [3:0]  clk_a,
    output logic [3:0]  clk_b,
    output logic [3:0]  clk_c,
    output logic        clk_fb,
    output logic        drive_en
);

    logic                 div_rst;
    logic [1:0]           bank_sel [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_ph;
    logic [NUM_OUTS-1:0]  outs;
    logic                 fb_ph;

    assign div_rst     = rst | ~out_en;
    assign bank_sel[0] = sel_a;
    assign bank_sel[1] = sel_b;
    assign bank_sel[2] = sel_c;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic ph;

            clkdiv_counter #(.KIND(bank_e'(b)), .SEL_W(2)) u_cnt (
                .clk   (clk),
                .rst   (div_rst),
                .sel   (bank_sel[b]),
                .phase (ph)
            );
            assign bank_ph[b] = ph;

            for (genvar o = 0; o < OUTS_PER_BANK; o++) begin : g_out
                localparam logic FLIP = (b == NUM_BANKS - 1) && (o >= OUTS_PER_BANK - 2);
                logic raw;
                assign raw = ph ^ (FLIP & inv_c);

                clkdiv_gate u_gate (
                    .clk    (clk),
                    .rst    (rst),
                    .raw    (raw),
                    .freeze (freeze[b*OUTS_PER_BANK + o]),
                    .q      (outs[b*OUTS_PER_BANK + o])
                );
            end
        end
    endgenerate

    clkdiv_counter #(.KIND(BANK_FB), .SEL_W(3)) u_fb_cnt (
        .clk   (clk),
        .rst   (div_rst),
        .sel   (sel_fb),
        .phase (fb_ph)
    );

    always_ff @(posedge clk) begin
        if (rst) drive_en <= 1'b0;
        else     drive_en <= out_en;
    end

    assign clk_a  = outs[OUTS_PER_BANK-1:0];
    assign clk_b  = outs[2*OUTS_PER_BANK-1:OUTS_PER_BANK];
    assign clk_c  = outs[3*OUTS_PER_BANK-1:2*OUTS_PER_BANK];
    assign clk_fb = fb_ph;

    // R8: a low enable drops the flag and parks every divider low
    assert_disable_flag_R8: assert property (@(posedge clk) disable iff (rst)
        !out_en |=> (!drive_en && bank_ph == '0 && !fb_ph));

    // R10: all dividers rise together on leaving reset
    assert_aligned_start_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(div_rst) |=> (&bank_ph && fb_ph));

endmodule

// File: tb/clkdiv_banks_tb.sv
module clkdiv_banks_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        out_en = 1'b1;
    logic [1:0]  sel_a = '0, sel_b = '0, sel_c = '0;
    logic [2:0]  sel_fb = '0;
    logic        inv_c = 1'b0;
    logic [11:0] freeze = '0;
    logic [3:0]  clk_a, clk_b, clk_c;
    logic        clk_fb, drive_en;

    int vectors = 0;
    int fails   = 0;
    int cycle   = 0;

    // reference model state: divider 0..2 = banks A..C, 3 = feedback
    bit act [4];
    int pos [4];
    int per [4];
    bit hold [12];
    bit exp_den;

    always #5 clk = ~clk;

    clkdiv_banks u_dut (
        .clk(clk), .rst(rst), .out_en(out_en),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb),
        .inv_c(inv_c), .freeze(freeze),
        .clk_a(clk_a), .clk_b(clk_b), .clk_c(clk_c), .clk_fb(clk_fb),
        .drive_en(drive_en)
    );

    // Periods from the requirements: R1 A, R2 B, R3 C, R4 feedback
    function automatic int period_of(int d);
        case (d)
            0:       return (sel_a == 2'd3) ? 12 : 4 + 2 * int'(sel_a);
            1:       return 4 + 2 * int'(sel_b);
            2:       return 2 + 2 * int'(sel_c);
            default: return (4 + 2 * int'(sel_fb[1:0])) * (sel_fb[2] ? 2 : 1);
        endcase
    endfunction

    function automatic bit ph_of(int d);
        return act[d] && (pos[d] < per[d] / 2);
    endfunction

    // R7: c2 and c3 (outputs 10 and 11) carry the inversion
    function automatic bit raw_of(int i);
        return ph_of(i / 4) ^ ((i >= 10) && inv_c);
    endfunction

    task automatic tick(input string tag);
        logic [12:0] exp_out;
        logic [12:0] got;
        @(posedge clk);
        for (int i = 0; i < 12; i++) begin
            if (rst)              hold[i] = 1'b0;
            else if (!raw_of(i))  hold[i] = freeze[i];
        end
        for (int d = 0; d < 4; d++) begin
            if (rst || !out_en) begin
                act[d] = 1'b0;
            end else if (!act[d]) begin
                act[d] = 1'b1;
                pos[d] = 0;
                per[d] = period_of(d);
            end else begin
                pos[d]++;
                if (pos[d] == per[d]) begin
                    pos[d] = 0;
                    per[d] = period_of(d);
                end
            end
        end
        exp_den = !rst && out_en;
        cycle++;
        @(negedge clk);
        for (int i = 0; i < 12; i++) exp_out[i] = raw_of(i) & ~hold[i];
        exp_out[12] = ph_of(3);
        got = {clk_fb, clk_c, clk_b, clk_a};
        vectors++;
        if (got !== exp_out || drive_en !== exp_den) begin
            fails++;
            $display("FAIL %s cycle %0d outputs got %h exp %h drive_en got %b exp %b",
                     tag, cycle, got, exp_out, drive_en, exp_den);
        end
    endtask

    initial begin
        int unsigned lcg;
        lcg = 32'h1234_5678;
        for (int d = 0; d < 4; d++) begin act[d] = 0; pos[d] = 0; per[d] = 2; end
        for (int i = 0; i < 12; i++) hold[i] = 0;

        // R9 reset state, with a full freeze mask that reset must clear
        freeze = '1;
        repeat (4) tick("R9 reset");
        freeze = '0;
        rst = 1'b0;

        // R1 R2 R3 R4 R10: every select combination from an aligned start
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++)
                    for (int f = 0; f < 8; f++) begin
                        sel_a = 2'(a); sel_b = 2'(b); sel_c = 2'(c); sel_fb = 3'(f);
                        out_en = 1'b0;
                        tick("R8 disable");
                        out_en = 1'b1;
                        repeat (40) tick("R1 R2 R3 R4 R10 ratio sweep");
                    end

        // R7 inversion of c2 and c3
        sel_c = 2'd1;
        inv_c = 1'b1;
        repeat (30) tick("R7 inverted");
        inv_c = 1'b0;
        repeat (10) tick("R7 plain");

        // R5 R6 freeze mask moving at odd intervals, with and without inversion
        sel_a = 2'd3; sel_b = 2'd2; sel_c = 2'd2; sel_fb = 3'd5;
        for (int s = 0; s < 120; s++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            freeze = lcg[27:16];
            if (s == 60) inv_c = 1'b1;
            repeat (3) tick("R5 R6 freeze");
        end
        freeze = '0;
        repeat (30) tick("R5 release");
        inv_c = 1'b0;

        // R11 select changes land mid-period
        for (int s = 0; s < 80; s++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            sel_a = lcg[17:16]; sel_b = lcg[19:18];
            sel_c = lcg[21:20]; sel_fb = lcg[24:22];
            repeat (5) tick("R11 select change");
        end

        // R8 disable mid-run, then resume
        out_en = 1'b0;
        repeat (6) tick("R8 disabled");
        out_en = 1'b1;
        repeat (30) tick("R8 R10 resume");

        // R9 reset clears freezes while running
        freeze = 12'hFFF;
        repeat (30) tick("R5 all frozen");
        freeze = '0;
        rst = 1'b1;
        tick("R9 reset pulse");
        rst = 1'b0;
        repeat (30) tick("R9 R10 after reset");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired at cycle %0d got running exp finished", cycle);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule